// File: doc/BRIEF.md
# Multi-Channel Interval Timer Bank

The block holds a parameterised set of independent interval timer channels behind a single word-addressed register port. Each channel owns a control/status word, a load word and a live count. Software writes a start value into the load word, then writes the control word with the run bit set. The channel restarts from the load value and steps once for every cycle on which the shared `tick` input is high. It can step up or down.

When a channel reaches its terminal count, it latches an expiry flag. With the repeat option set, it reloads from the load word and keeps running. Without it, the channel parks on the terminal value. Every channel whose flag and flag-enable are both set drives the single level-sensitive interrupt output. Software clears a flag by writing the control word.

Top module: `ivtimer_bank`

## Requirements
- R1: After reset every control, load and count word of every channel reads zero and `irq` is low.
- R2: The word address is channel*4 + offset. Offset 0 selects the control word, offset 1 the load word and offset 2 the count. Offset 3 always reads zero and a write to it changes nothing. Read data is combinational on `addr`.
- R3: The control word keeps bits 10:0 of the written data and reads bits 31:11 as zero. The bits with an effect are bit 1 (1 = count down, 0 = count up), bit 4 (repeat), bit 6 (flag enable), bit 7 (run) and bit 8 (expiry flag). Bits 0, 2, 3, 5, 9 and 10 are stored and read back but change nothing.
- R4: A control write with bit 7 set copies the load word into the count, and the new count is visible on the following cycle. Any parked state is cleared by the same write.
- R5: The count changes by one only on a cycle with `tick` high, bit 7 set, the channel not parked and no control write to that channel. On every other cycle it holds.
- R6: A stepping cycle that finds the count at its terminal value is an expiry and sets bit 8. The terminal value is zero when counting down and all-ones when counting up.
- R7: At an expiry with bit 4 set, the count reloads from the load word and the channel keeps stepping.
- R8: At an expiry with bit 4 clear, the count stays on the terminal value and no further step or expiry happens until a control write with bit 7 set.
- R9: After any control write, bit 8 reads zero, whatever the written data held. This also holds when an expiry falls in the same cycle as the write.
- R10: `irq` is high exactly while some channel has both bit 8 and bit 6 set. It follows a write or an expiry on the next cycle.
- R11: Writes and steps in one channel leave every other channel's words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Shared count enable for all channels |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | ADDR_W | Word address (channel*4 + offset) |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for the word at `addr` |
| irq | output | 1 | Shared level interrupt |

## Verification
A corrupted count shows at the count word at once, and the expiry time of that channel moves by the size of the error. A wrong direction or terminal decode shows as a flag that rises one or more ticks early or late, or never, and `irq` follows one cycle later. A parked state that is not cleared, or one that is entered wrongly, shows as a count that stops moving while the run bit reads set. A flag that survives a control write keeps `irq` high on the cycle after that write.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;
  localparam int CTRL_W   = 11;
  localparam int CB_DOWN  = 1;
  localparam int CB_REPT  = 4;
  localparam int CB_FLEN  = 6;
  localparam int CB_RUN   = 7;
  localparam int CB_FLAG  = 8;

  typedef enum logic [1:0] {
    OFS_CTRL  = 2'd0,
    OFS_LOAD  = 2'd1,
    OFS_COUNT = 2'd2,
    OFS_SPARE = 2'd3
  } ofs_e;
endpackage

// File: rtl/ivt_channel.sv
`timescale 1ns/1ps
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ctrl_we,
  input  logic              load_we,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]  load_q,
  output logic [CNT_W-1:0]  cnt_q
);
  logic [CTRL_W-1:0] ctrl_d;
  logic [CNT_W-1:0]  load_d, cnt_d;
  logic              park_q, park_d;
  logic              at_term, step, expire;

  always_comb begin
    at_term = ctrl_q[CB_DOWN] ? (cnt_q == '0) : (cnt_q == '1);
    step    = tick & ctrl_q[CB_RUN] & ~park_q;
    expire  = step & at_term;

    ctrl_d = ctrl_q;
    load_d = load_q;
    cnt_d  = cnt_q;
    park_d = park_q;

    if (load_we) load_d = wdata;

    if (ctrl_we) begin
      ctrl_d          = wdata[CTRL_W-1:0];
      ctrl_d[CB_FLAG] = 1'b0;
      if (wdata[CB_RUN]) begin
        cnt_d  = load_q;
        park_d = 1'b0;
      end
    end else if (expire) begin
      ctrl_d[CB_FLAG] = 1'b1;
      if (ctrl_q[CB_REPT]) cnt_d  = load_q;
      else                 park_d = 1'b1;
    end else if (step) begin
      cnt_d = ctrl_q[CB_DOWN] ? cnt_q - CNT_W'(1) : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
      park_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      cnt_q  <= cnt_d;
      park_q <= park_d;
    end
  end
endmodule

// File: rtl/ivt_readmux.sv
`timescale 1ns/1ps
module ivt_readmux
  import ivt_pkg::*;
#(
  parameter int N_CH  = 2,
  parameter int CNT_W = 32,
  parameter int CH_W  = 1
) (
  input  logic [CH_W-1:0]                addr_ch,
  input  logic [1:0]                     addr_ofs,
  input  logic [N_CH-1:0][CTRL_W-1:0]    ctrl_v,
  input  logic [N_CH-1:0][CNT_W-1:0]     load_v,
  input  logic [N_CH-1:0][CNT_W-1:0]     cnt_v,
  output logic [CNT_W-1:0]               rdata
);
  always_comb begin
    rdata = '0;
    if (int'(addr_ch) < N_CH) begin
      case (ofs_e'(addr_ofs))
        OFS_CTRL:  rdata = CNT_W'(ctrl_v[addr_ch]);
        OFS_LOAD:  rdata = load_v[addr_ch];
        OFS_COUNT: rdata = cnt_v[addr_ch];
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ivtimer_bank.sv
`timescale 1ns/1ps
module ivtimer_bank
  import ivt_pkg::*;
#(
  parameter int N_CH   = 2,
  parameter int CNT_W  = 32,
  parameter int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  parameter int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [CH_W-1:0] addr_ch;
  logic [1:0]      addr_ofs;
  assign addr_ch  = addr[ADDR_W-1:2];
  assign addr_ofs = addr[1:0];

  logic [N_CH-1:0][CTRL_W-1:0] ctrl_v;
  logic [N_CH-1:0][CNT_W-1:0]  load_v, cnt_v;
  logic [N_CH-1:0]             ctrl_we_v, load_we_v;
  logic [N_CH-1:0]             flag_v, flen_v, run_v, down_v;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    assign ctrl_we_v[k] = wr_en && (addr_ch == CH_W'(k)) && (addr_ofs == OFS_CTRL);
    assign load_we_v[k] = wr_en && (addr_ch == CH_W'(k)) && (addr_ofs == OFS_LOAD);

    ivt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .tick    (tick),
      .ctrl_we (ctrl_we_v[k]),
      .load_we (load_we_v[k]),
      .wdata   (wdata),
      .ctrl_q  (ctrl_v[k]),
      .load_q  (load_v[k]),
      .cnt_q   (cnt_v[k])
    );

    assign flag_v[k] = ctrl_v[k][CB_FLAG];
    assign flen_v[k] = ctrl_v[k][CB_FLEN];
    assign run_v[k]  = ctrl_v[k][CB_RUN];
    assign down_v[k] = ctrl_v[k][CB_DOWN];
  end

  assign irq = |(flag_v & flen_v);

  ivt_readmux #(.N_CH(N_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_rd (
    .addr_ch  (addr_ch),
    .addr_ofs (addr_ofs),
    .ctrl_v   (ctrl_v),
    .load_v   (load_v),
    .cnt_v    (cnt_v),
    .rdata    (rdata)
  );
endmodule

// File: rtl/ivt_checker.sv
`timescale 1ns/1ps
module ivt_checker #(
  parameter int N_CH  = 2,
  parameter int CNT_W = 32
) (
  input logic                        clk,
  input logic                        rst_sync_n,
  input logic                        tick,
  input logic                        run_bit_in,
  input logic [N_CH-1:0]             ctrl_we_v,
  input logic [N_CH-1:0]             flag_v,
  input logic [N_CH-1:0]             run_v,
  input logic [N_CH-1:0]             down_v,
  input logic [N_CH-1:0][CNT_W-1:0]  cnt_v,
  input logic [N_CH-1:0][CNT_W-1:0]  load_v,
  input logic                        irq
);
  // R1: coming out of reset the interrupt is quiet and counts are zero
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (!irq && cnt_v == '0));

  for (genvar k = 0; k < N_CH; k++) begin : g_chk
    assert_ctrl_write_clears_flag_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ctrl_we_v[k] |=> !flag_v[k]);

    assert_run_write_restarts_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (ctrl_we_v[k] && run_bit_in) |=> (cnt_v[k] == $past(load_v[k])));

    assert_no_tick_holds_count_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!tick && !ctrl_we_v[k]) |=> $stable(cnt_v[k]));

    assert_flag_only_at_terminal_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(flag_v[k]) |-> $past(tick && run_v[k] &&
        (down_v[k] ? (cnt_v[k] == '0) : (cnt_v[k] == '1))));
  end
endmodule

bind ivtimer_bank ivt_checker #(.N_CH(N_CH), .CNT_W(CNT_W)) u_ivt_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .tick       (tick),
  .run_bit_in (wdata[ivt_pkg::CB_RUN]),
  .ctrl_we_v  (ctrl_we_v),
  .flag_v     (flag_v),
  .run_v      (run_v),
  .down_v     (down_v),
  .cnt_v      (cnt_v),
  .load_v     (load_v),
  .irq        (irq)
);

// File: tb/ivtimer_bank_test.sv
`timescale 1ns/1ps
module ivtimer_bank_test;
  localparam int N_CH = 2, CNT_W = 32, ADDR_W = 3;

  logic clk, rst_n, tick, wr_en, irq;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  wdata, rdata;
  int n_run, n_fail;
  bit done;

  ivtimer_bank #(.N_CH(N_CH), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(a[ADDR_W-1:0], d); check("R1 reset word", d, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_addr;
    logic [31:0] d;
    wr(3'd1, 32'h0000_1234);
    wr(3'd5, 32'h0000_ABCD);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd1, d); check("R2 ch0 load", d, 32'h1234);
    rd(3'd5, d); check("R11 ch1 load separate", d, 32'hABCD);
    rd(3'd3, d); check("R2 spare offset ch0", d, 32'h0);
    rd(3'd7, d); check("R2 spare offset ch1", d, 32'h0);
    wr(3'd0, 32'hFFFF_062D);
    rd(3'd0, d); check("R3 inert bits stored", d, 32'h0000_062D);
    ticks(4);
    rd(3'd2, d); check("R5 no run no step", d, 32'h0);
    check("R3 inert bits no irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_down_oneshot;
    logic [31:0] d;
    wr(3'd1, 32'd5);
    wr(3'd0, 32'h82);
    rd(3'd2, d); check("R4 restart from load", d, 32'd5);
    ticks(3);
    rd(3'd2, d); check("R5 down steps", d, 32'd2);
    ticks(2);
    rd(3'd0, d); check("R6 no flag before terminal tick", d, 32'h82);
    ticks(1);
    rd(3'd0, d); check("R6 flag at zero", d, 32'h182);
    check("R10 irq masked by flag enable", {31'b0, irq}, 32'h0);
    ticks(3);
    rd(3'd2, d); check("R8 parked on zero", d, 32'h0);
    wr(3'd0, 32'h182);
    rd(3'd0, d); check("R9 write clears flag", d, 32'h82);
    rd(3'd2, d); check("R4 re-run reloads", d, 32'd5);
    ticks(1);
    rd(3'd2, d); check("R8 unparked after re-run", d, 32'd4);
    wr(3'd0, 32'h02);
  endtask

  task automatic t_up_repeat;
    logic [31:0] d;
    wr(3'd5, 32'hFFFF_FFFD);
    wr(3'd4, 32'hD0);
    rd(3'd6, d); check("R4 ch1 restart", d, 32'hFFFF_FFFD);
    ticks(2);
    rd(3'd6, d); check("R5 up steps", d, 32'hFFFF_FFFF);
    check("R10 irq low before expiry", {31'b0, irq}, 32'h0);
    ticks(1);
    rd(3'd6, d); check("R7 reload on expiry", d, 32'hFFFF_FFFD);
    rd(3'd4, d); check("R6 up flag", d, 32'h1D0);
    check("R10 irq high", {31'b0, irq}, 32'h1);
    rd(3'd2, d); check("R11 ch0 untouched", d, 32'd4);
    ticks(1);
    rd(3'd6, d); check("R7 keeps running", d, 32'hFFFF_FFFE);
    wr(3'd4, 32'h50);
    check("R10 irq drops after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd4, 32'hD0);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 3'd4; wdata = 32'hC0;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(3'd4, d); check("R9 write beats expiry", d, 32'hC0);
    check("R9 irq low after race", {31'b0, irq}, 32'h0);
    ticks(1);
    rd(3'd4, d); check("R6 one-shot up flag", d, 32'h1C0);
    check("R10 irq on one-shot", {31'b0, irq}, 32'h1);
    ticks(2);
    rd(3'd6, d); check("R8 parked on all-ones", d, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_addr();
    t_down_oneshot();
    t_up_repeat();
    t_race();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule